// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a free-running up-counter with a small register bank on a word-addressed bus. Software picks one of three tick strobes as the count source, starts the counter, and loads a compare value. When the counter steps onto that value, a sticky flag is raised. If the interrupt mask allows it, a registered interrupt line follows one cycle later. A match never restarts the counter. It keeps counting and wraps to zero past its all-ones value.

All tick sources are single-cycle enable strobes in the one clock domain of the block. The oscillator strobe has its own programmable pre-divider, and it is counted only while its path-enable bit is set. Software typically reads the counter, adds a delta, and writes the sum as the next compare value. Clearing the control register parks the counter at zero.

Top module: `cmt_timer`

## Requirements
- R1: After a synchronous reset, every register reads 0 and the interrupt output is 0.
- R2: Register map by byte address: control 0x00, pre-divider 0x04, flag 0x08, interrupt mask 0x0C, compare 0x10, counter 0x24. In the control register only bits 0, 3 and 6 to 10 are stored. In the pre-divider register only bits [15:12] are stored. In the mask register only bit 0 is stored. The compare register stores every bit. All other bits read 0, and read data appears one clock after the read strobe.
- R3: The counter at 0x24 is read-only. A write to it has no effect.
- R4: Control bit 0 is the run bit. While it is 0, the counter is held at 0 and ignores every tick.
- R5: Control bits [8:6] choose the source. Code 1 counts the bus tick and code 2 counts the peripheral tick. Every other code except 5 counts nothing. A strobe from a source that is not selected never advances the counter.
- R6: Code 5 counts the oscillator tick divided by (pre-divider field + 1), but only while control bit 10 is 1. With bit 10 at 0, code 5 counts nothing.
- R7: On the clock edge where the counter steps to a value equal to the compare register, flag bit 0 is set. The counter keeps counting through the match and wraps from all ones to 0.
- R8: Writing 1 to flag bit 0 clears it, and writing 0 leaves it unchanged. If a match and a clearing write fall in the same cycle, the flag ends up set.
- R9: The interrupt output is a register that takes flag AND mask bit 0, so it follows them one clock later. Clearing the mask drops the interrupt but leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| bus_tick | input | 1 | Bus-clock tick strobe |
| per_tick | input | 1 | Peripheral-clock tick strobe |
| osc_tick | input | 1 | Oscillator tick strobe, before the pre-divider |
| irq | output | 1 | Registered compare interrupt |

## Verification
Faults in the source selection or the pre-divider show up on the next counter read as a count that is off by a known number of strobes. A divider phase that is out of step shifts the first divided count by up to one oscillator period. A wrong flag state reaches the port at the next read of 0x08, and at `irq` one clock later if the mask is set. A counter that restarted on a match would read low at once after the match. Both the set-over-clear race and the wrap are driven on the exact edge where they occur.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int DATA_W = 32;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_PDIV = 'h04;
  localparam int OFS_STAT = 'h08;
  localparam int OFS_MASK = 'h0C;
  localparam int OFS_CMP  = 'h10;
  localparam int OFS_CNT  = 'h24;

  localparam int BIT_RUN   = 0;
  localparam int BIT_WAIT  = 3;
  localparam int SRC_LSB   = 6;
  localparam int BIT_FREE  = 9;
  localparam int BIT_OSCEN = 10;
  localparam int PDIV_LSB  = 12;

  localparam logic [2:0] SRC_BUS = 3'd1;
  localparam logic [2:0] SRC_PER = 3'd2;
  localparam logic [2:0] SRC_OSC = 3'd5;
endpackage

// File: rtl/cmt_regs.sv
module cmt_regs
  import cmt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int PDIV_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              flag_val,
  output logic              run,
  output logic [2:0]        src,
  output logic              osc_en,
  output logic [PDIV_W-1:0] osc_div,
  output logic              mask,
  output logic [CNT_W-1:0]  cmp,
  output logic              stat_clr,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_PDIV = ADDR_W'(OFS_PDIV);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFS_CMP);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);

  logic              wait_en;
  logic              free_run;
  logic [DATA_W-1:0] rd_mux;

  assign stat_clr = wr_en && (addr == A_STAT) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      wait_en  <= 1'b0;
      src      <= 3'd0;
      free_run <= 1'b0;
      osc_en   <= 1'b0;
      osc_div  <= '0;
      mask     <= 1'b0;
      cmp      <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          run      <= wdata[BIT_RUN];
          wait_en  <= wdata[BIT_WAIT];
          src      <= wdata[SRC_LSB +: 3];
          free_run <= wdata[BIT_FREE];
          osc_en   <= wdata[BIT_OSCEN];
        end
        A_PDIV: osc_div <= wdata[PDIV_LSB +: PDIV_W];
        A_MASK: mask    <= wdata[0];
        A_CMP:  cmp     <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL: begin
        rd_mux[BIT_RUN]        = run;
        rd_mux[BIT_WAIT]       = wait_en;
        rd_mux[SRC_LSB +: 3]   = src;
        rd_mux[BIT_FREE]       = free_run;
        rd_mux[BIT_OSCEN]      = osc_en;
      end
      A_PDIV: rd_mux[PDIV_LSB +: PDIV_W] = osc_div;
      A_STAT: rd_mux[0] = flag_val;
      A_MASK: rd_mux[0] = mask;
      A_CMP:  rd_mux = DATA_W'(cmp);
      A_CNT:  rd_mux = DATA_W'(cnt_val);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/cmt_tick_sel.sv
module cmt_tick_sel
  import cmt_pkg::*;
#(
  parameter int PDIV_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [2:0]        src,
  input  logic              osc_en,
  input  logic [PDIV_W-1:0] osc_div,
  input  logic              bus_tick,
  input  logic              per_tick,
  input  logic              osc_tick,
  output logic              tick
);
  logic [PDIV_W-1:0] dcnt;
  logic              osc_live;
  logic              osc_out;

  assign osc_live = run && osc_en && (src == SRC_OSC);
  assign osc_out  = osc_live && osc_tick && (dcnt >= osc_div);

  always_ff @(posedge clk) begin
    if (rst || !osc_live) dcnt <= '0;
    else if (osc_tick) begin
      if (dcnt >= osc_div) dcnt <= '0;
      else                 dcnt <= dcnt + 1'b1;
    end
  end

  always_comb begin
    tick = 1'b0;
    if (run) begin
      case (src)
        SRC_BUS: tick = bus_tick;
        SRC_PER: tick = per_tick;
        SRC_OSC: tick = osc_out;
        default: tick = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp,
  input  logic             stat_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             hit;

  assign cnt_nxt = cnt + 1'b1;
  assign hit     = run && tick && (cnt_nxt == cmp);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (stat_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int PDIV_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              bus_tick,
  input  logic              per_tick,
  input  logic              osc_tick,
  output logic              irq
);
  logic              run;
  logic [2:0]        src;
  logic              osc_en;
  logic [PDIV_W-1:0] osc_div;
  logic              mask;
  logic [CNT_W-1:0]  cmp;
  logic              stat_clr;
  logic              tick;
  logic [CNT_W-1:0]  cnt;
  logic              flag;

  cmt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PDIV_W(PDIV_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt_val(cnt), .flag_val(flag), .run(run), .src(src),
    .osc_en(osc_en), .osc_div(osc_div), .mask(mask), .cmp(cmp),
    .stat_clr(stat_clr), .rdata(rdata)
  );

  cmt_tick_sel #(.PDIV_W(PDIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(run), .src(src), .osc_en(osc_en),
    .osc_div(osc_div), .bus_tick(bus_tick), .per_tick(per_tick),
    .osc_tick(osc_tick), .tick(tick)
  );

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .cmp(cmp),
    .stat_clr(stat_clr), .cnt(cnt), .flag(flag)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= flag && mask;
  end
endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk
  import cmt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wbit0,
  input logic              run,
  input logic [2:0]        src,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt_val,
  input logic [CNT_W-1:0]  cmp_val,
  input logic              flag,
  input logic              mask,
  input logic              irq
);
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_val == '0)); // R4

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt_val)); // R4

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && tick) |=> (cnt_val == CNT_W'($past(cnt_val) + 1'b1))); // R7

  AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    tick |-> (src == SRC_BUS || src == SRC_PER || src == SRC_OSC)); // R5

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> ($past(tick) && cnt_val == $past(cmp_val))); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !(wr_en && addr == ADDR_W'(OFS_STAT) && wbit0)) |=> flag); // R8

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag && mask)); // R9
endmodule

bind cmt_timer cmt_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wbit0(wdata[0]),
  .run(run), .src(src), .tick(tick), .cnt_val(cnt), .cmp_val(cmp),
  .flag(flag), .mask(mask), .irq(irq)
);

// File: tb/tb_cmt_timer.sv
module tb_cmt_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_s;
  logic        bus_tick = 1'b0, per_tick = 1'b0, osc_tick = 1'b0;
  logic        irq, irq_s;
  int          checks = 0, errors = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  cmt_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .bus_tick(bus_tick), .per_tick(per_tick),
    .osc_tick(osc_tick), .irq(irq)
  );

  cmt_timer #(.CNT_W(8)) dut_w8 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_s), .bus_tick(bus_tick), .per_tick(per_tick),
    .osc_tick(osc_tick), .irq(irq_s)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  // kind: 0 bus, 1 peripheral, 2 oscillator
  task automatic pulse(input int kind, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_tick = (kind == 0); per_tick = (kind == 1); osc_tick = (kind == 2);
      @(negedge clk);
      bus_tick = 1'b0; per_tick = 1'b0; osc_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    rd(8'h00, v); check("R1 ctrl", v, 0);
    rd(8'h04, v); check("R1 pdiv", v, 0);
    rd(8'h08, v); check("R1 flag", v, 0);
    rd(8'h0C, v); check("R1 mask", v, 0);
    rd(8'h10, v); check("R1 cmp", v, 0);
    rd(8'h24, v); check("R1 cnt", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_regs;
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R2 ctrl mask", v, 32'h0000_07C9);
    wr(8'h00, 0);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); check("R2 pdiv mask", v, 32'h0000_F000);
    wr(8'h0C, 32'h0000_FFFF); rd(8'h0C, v); check("R2 mask bit", v, 1);
    wr(8'h10, 32'hA5A5_1234); rd(8'h10, v); check("R2 cmp", v, 32'hA5A5_1234);
    rd(8'h18, v); check("R2 unmapped", v, 0);
    wr(8'h04, 0); wr(8'h0C, 0); wr(8'h10, 0);
  endtask

  task automatic t_cnt_ro;
    wr(8'h00, 32'h41); pulse(0, 2);
    wr(8'h24, 32'h55); rd(8'h24, v); check("R3 counter ignores write", v, 2);
    wr(8'h00, 0);
  endtask

  task automatic t_src;
    wr(8'h00, 32'h40); pulse(0, 3); rd(8'h24, v); check("R4 run=0 holds 0", v, 0);
    wr(8'h00, 32'h41); pulse(1, 3); pulse(2, 3);
    rd(8'h24, v); check("R5 other strobes ignored", v, 0);
    pulse(0, 5); rd(8'h24, v); check("R5 bus source", v, 5);
    wr(8'h00, 0); rd(8'h24, v); check("R4 stop clears", v, 0);
    wr(8'h00, 32'h81); pulse(1, 4); pulse(0, 2);
    rd(8'h24, v); check("R5 peripheral source", v, 4);
    wr(8'h00, 32'hC1); pulse(0, 2); pulse(1, 2); pulse(2, 2);
    rd(8'h24, v); check("R5 code 3 counts nothing", v, 4);
    wr(8'h00, 0);
  endtask

  task automatic t_osc;
    wr(8'h04, 32'h0000_2000);
    wr(8'h00, 32'h141); pulse(2, 6); rd(8'h24, v); check("R6 path off", v, 0);
    wr(8'h00, 32'h541); pulse(2, 6); rd(8'h24, v); check("R6 divide by 3", v, 2);
    pulse(2, 2); rd(8'h24, v); check("R6 partial period", v, 2);
    pulse(2, 1); rd(8'h24, v); check("R6 period done", v, 3);
    wr(8'h04, 32'h0000_7000); pulse(2, 7); rd(8'h24, v); check("R6 divide by 8 early", v, 3);
    pulse(2, 1); rd(8'h24, v); check("R6 divide by 8", v, 4);
    wr(8'h00, 0); wr(8'h04, 0);
  endtask

  task automatic t_match;
    wr(8'h10, 3); wr(8'h00, 32'h41);
    pulse(0, 2); rd(8'h08, v); check("R7 no early flag", v, 0);
    pulse(0, 1); rd(8'h08, v); check("R7 flag on match", v, 1);
    check("R9 masked irq", {31'b0, irq}, 0);
    pulse(0, 2); rd(8'h24, v); check("R7 counts through match", v, 5);
    wr(8'h08, 0); rd(8'h08, v); check("R8 write 0 keeps flag", v, 1);
    wr(8'h0C, 1); @(negedge clk); check("R9 irq raised", {31'b0, irq}, 1);
    wr(8'h0C, 0); @(negedge clk); check("R9 irq masked", {31'b0, irq}, 0);
    rd(8'h08, v); check("R9 mask keeps flag", v, 1);
    wr(8'h08, 1); rd(8'h08, v); check("R8 W1C clears", v, 0);
  endtask

  task automatic t_race;
    wr(8'h10, 7); pulse(0, 1);
    @(negedge clk); bus_tick = 1'b1; wr_en = 1'b1; addr = 8'h08; wdata = 1;
    @(negedge clk); bus_tick = 1'b0; wr_en = 1'b0;
    rd(8'h24, v); check("R8 race count", v, 7);
    rd(8'h08, v); check("R8 set beats clear", v, 1);
    wr(8'h08, 1); wr(8'h00, 0);
  endtask

  task automatic t_wrap;
    wr(8'h10, 1); wr(8'h00, 32'h41);
    pulse(0, 255); wr(8'h08, 1);
    rd(8'h24, v); check("R7 small at 255", rdata_s, 255);
    pulse(0, 1); rd(8'h24, v); check("R7 wrap to 0", rdata_s, 0);
    pulse(0, 1); rd(8'h24, v); check("R7 after wrap", rdata_s, 1);
    check("R7 wide no restart", v, 257);
    rd(8'h08, v); check("R7 match after wrap", rdata_s, 1);
    wr(8'h00, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_cnt_ro();
    t_src();
    t_osc();
    t_match();
    t_race();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule